// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame should be kept because of its group (multicast) destination address. The six destination address bytes arrive one per cycle, in the order they appear on the wire. The block runs them through the Ethernet CRC-32 polynomial and keeps the upper eight bits of the resulting register as a bin number. It then looks that bin up in a 256-bit table. Software loads the table through eight 32-bit registers.

When the last byte has been accepted, the block produces a single-cycle done pulse. The pulse comes with two flags. The pass flag says whether the frame is kept. The not-applicable flag is raised when the address is an individual one, with bit 0 of the first byte clear. Such an address never consults the table. A promiscuous control input forces pass for every address. Matching of individual addresses and parsing of the frame are left to neighbouring logic.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash register is preset to 0xFFFFFFFF on the first valid byte after reset or after a byte flagged last. Each byte is consumed bit 0 first. For each bit the feedback is the register's bit 31 XOR the data bit. The register then shifts left by one, and 0x04C11DB7 is XORed in when the feedback is 1. No final inversion is applied.
- R2: The bin number is bits 31:24 of the hash register after the last byte.
- R3: Bits 7:5 of the bin select a table register. Bits 4:0 select bit (31 − value) of that register. Bin 0 is therefore register 0 bit 31, and bin 255 is register 7 bit 0.
- R4: After reset all eight table registers read zero, so no group address passes, and done is low.
- R5: A cycle with reg_wr_en high writes reg_wdata into the register numbered reg_sel. reg_rdata always shows the register numbered reg_sel, without added delay.
- R6: The group bit is bit 0 of the first address byte. When it is 0, na is 1 and pass is 0 (unless R7 applies), whatever the table holds. When it is 1, na is 0 and pass equals the table bit.
- R7: With promisc high, pass is 1 for every address, group or individual. na still reports the group bit.
- R8: If the last byte is sampled at clock edge k, done is high only between edges k+1 and k+2, with pass and na valid alongside it. Promisc and the table are sampled at edge k+1. Pass and na then hold until the next decision.
- R9: Cycles with in_valid low leave the hash and the group bit unchanged, whatever in_byte carries.
- R10: An address may start in the cycle right after the previous one's last byte, and is hashed from a fresh preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_byte carries an address byte |
| in_byte | input | 8 | Address byte, wire order |
| in_last | input | 1 | This byte is the final one of the address |
| promisc | input | 1 | Accept every address |
| reg_wr_en | input | 1 | Write strobe for the table registers |
| reg_sel | input | 3 | Table register number |
| reg_wdata | input | 32 | Table write data |
| reg_rdata | output | 32 | Contents of the selected table register |
| done | output | 1 | One-cycle decision strobe |
| pass | output | 1 | Frame is accepted |
| na | output | 1 | Address is individual, so the table was not consulted |

## Verification
The decision comes two edges after the edge that samples the last byte. The bench drives inputs on falling edges. It checks that done is still low at the falling edge just after the last byte. It reads done, pass and na at the next falling edge, and confirms done has dropped one cycle later. Table reads have no delay and are compared at the falling edge after the write edge. For back-to-back addresses, the bench logs every falling edge and requires each pulse in exactly the cycle predicted from its byte count. Expected bins come from a bit-serial CRC written in the bench.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int unsigned MHF_BYTE_W  = 8;
   localparam int unsigned MHF_CRC_W   = 32;
   localparam int unsigned MHF_BIN_W   = 8;
   localparam int unsigned MHF_WORD_W  = 32;
   localparam logic [31:0] MHF_POLY    = 32'h04C1_1DB7;
   localparam logic [31:0] MHF_PRESET  = 32'hFFFF_FFFF;

   typedef struct packed {
      logic done;
      logic pass;
      logic na;
   } mhf_verdict_t;
endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit #(
   parameter int unsigned          BYTE_W = mhf_pkg::MHF_BYTE_W,
   parameter int unsigned          CRC_W  = mhf_pkg::MHF_CRC_W,
   parameter logic [CRC_W-1:0]     POLY   = mhf_pkg::MHF_POLY,
   parameter logic [CRC_W-1:0]     PRESET = mhf_pkg::MHF_PRESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_last,
   output logic [CRC_W-1:0]  crc_q,
   output logic              group_q,
   output logic              final_q
);
   logic               fresh_q;
   logic [CRC_W-1:0]   stage [BYTE_W+1];

   assign stage[0] = fresh_q ? PRESET : crc_q;

   // one unrolled shift step per data bit, bit 0 of the byte first
   for (genvar b = 0; b < BYTE_W; b++) begin : g_step
      logic fb;
      assign fb = stage[b][CRC_W-1] ^ in_byte[b];
      assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q   <= PRESET;
         fresh_q <= 1'b1;
         group_q <= 1'b0;
         final_q <= 1'b0;
      end else begin
         final_q <= in_valid & in_last;
         if (in_valid) begin
            crc_q   <= stage[BYTE_W];
            fresh_q <= in_last;
            if (fresh_q) group_q <= in_byte[0];
         end
      end
   end
endmodule

// File: rtl/mhf_bin_table.sv
module mhf_bin_table #(
   parameter int unsigned BIN_W  = mhf_pkg::MHF_BIN_W,
   parameter int unsigned WORD_W = mhf_pkg::MHF_WORD_W,
   localparam int unsigned BINS  = 1 << BIN_W,
   localparam int unsigned NREG  = BINS / WORD_W,
   localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int unsigned POS_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   input  logic [BIN_W-1:0]  bin,
   output logic              hit
);
   logic [WORD_W-1:0] regs_q [NREG];
   logic [SEL_W-1:0]  bin_reg;
   logic [POS_W-1:0]  bin_pos;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       regs_q[r] <= '0;
         else if (wr_en && sel == SEL_W'(r)) regs_q[r] <= wdata;
      end
   end

   assign rdata   = regs_q[sel];
   // most significant bin bits choose the word, the rest count down from its MSB
   assign bin_reg = SEL_W'(bin >> POS_W);
   assign bin_pos = POS_W'(WORD_W - 1) - bin[POS_W-1:0];
   assign hit     = regs_q[bin_reg][bin_pos];
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 final_in,
   input  logic                 group_in,
   input  logic                 hit_in,
   input  logic                 promisc,
   output mhf_pkg::mhf_verdict_t verdict
);
   mhf_pkg::mhf_verdict_t v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q.done <= final_in;
         if (final_in) begin
            v_q.pass <= promisc | (group_in & hit_in);
            v_q.na   <= ~group_in;
         end
      end
   end

   assign verdict = v_q;
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
   parameter int unsigned BYTE_W = mhf_pkg::MHF_BYTE_W,
   parameter int unsigned CRC_W  = mhf_pkg::MHF_CRC_W,
   parameter int unsigned BIN_W  = mhf_pkg::MHF_BIN_W,
   parameter int unsigned WORD_W = mhf_pkg::MHF_WORD_W,
   localparam int unsigned NREG  = (1 << BIN_W) / WORD_W,
   localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_last,
   input  logic              promisc,
   input  logic              reg_wr_en,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              done,
   output logic              pass,
   output logic              na
);
   if (BIN_W > CRC_W) begin : g_bad_bin
      $error("bin width exceeds hash width");
   end
   if (((1 << BIN_W) % WORD_W) != 0 || NREG < 2) begin : g_bad_word
      $error("table bins must fill at least two whole registers");
   end

   logic [CRC_W-1:0] crc;
   logic             grp, fin, hit;
   mhf_pkg::mhf_verdict_t verdict;

   mhf_crc_unit #(.BYTE_W(BYTE_W), .CRC_W(CRC_W),
                  .POLY(CRC_W'(mhf_pkg::MHF_POLY)), .PRESET(CRC_W'(mhf_pkg::MHF_PRESET)))
   u_crc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .crc_q(crc), .group_q(grp), .final_q(fin)
   );

   mhf_bin_table #(.BIN_W(BIN_W), .WORD_W(WORD_W)) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .bin(crc[CRC_W-1 -: BIN_W]), .hit(hit)
   );

   mhf_decide u_decide (
      .clk(clk), .rst_n(rst_n), .final_in(fin), .group_in(grp),
      .hit_in(hit), .promisc(promisc), .verdict(verdict)
   );

   assign done = verdict.done;
   assign pass = verdict.pass;
   assign na   = verdict.na;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_last,
   input logic              promisc,
   input logic              reg_wr_en,
   input logic [SEL_W-1:0]  reg_sel,
   input logic [WORD_W-1:0] reg_wdata,
   input logic [WORD_W-1:0] reg_rdata,
   input logic              done,
   input logic              pass,
   input logic              na
);
   AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> ##1 done);                               // R8
   AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(in_valid && in_last, 2));                    // R8
   AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(promisc)) |-> pass);                                // R7
   AST_NA_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && na && !$past(promisc)) |-> !pass);                        // R6
   AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> (reg_sel != $past(reg_sel) || reg_rdata == $past(reg_wdata))); // R5
   AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(done)) |-> ($stable(pass) && $stable(na)));       // R8
endmodule

bind mcast_hash_filter mhf_checker #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .promisc(promisc), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
   .pass(pass), .na(na)
);

// File: tb/mcast_hash_filter_tb.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_last = 1'b0;
   logic        promisc = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        done, pass, na;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [31:0] model [8];
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #4 clk = ~clk;

   mcast_hash_filter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .promisc(promisc), .reg_wr_en(reg_wr_en),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .done(done), .pass(pass), .na(na)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b = a[47-8*i -: 8];
         for (int j = 0; j < 8; j++) begin
            logic fb = c[31] ^ b[j];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c;
   endfunction

   function automatic logic [7:0] ref_bin(input logic [47:0] a);
      logic [31:0] c = ref_crc(a);
      return c[31:24];
   endfunction

   function automatic bit ref_hit(input logic [47:0] a);
      logic [7:0] bn = ref_bin(a);
      return model[bn[7:5]][31 - bn[4:0]];
   endfunction

   task automatic next_addr(input bit grp, output logic [47:0] a);
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      a = rng[47:0];
      a[40] = grp;
   endtask

   task automatic write_reg(input int r, input logic [31:0] v);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = 3'(r); reg_wdata = v;
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0;
      model[r] = v;
   endtask

   task automatic send_addr(input logic [47:0] a, input int gap,
                            output logic d, output logic p, output logic n);
      for (int i = 0; i < 6; i++) begin
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0; in_byte = 8'hA5 ^ 8'(g + i); in_last = 1'b1;
            @(posedge clk);
         end
         @(negedge clk);
         in_valid = 1'b1; in_byte = a[47-8*i -: 8]; in_last = (i == 5);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      check(done == 1'b0, "R8 early done", 32'(done), 0);
      @(posedge clk);
      @(negedge clk);
      d = done; p = pass; n = na;
      @(posedge clk);
      @(negedge clk);
      check(done == 1'b0, "R8 pulse width", 32'(done), 0);
   endtask

   task automatic try_addr(input logic [47:0] a, input int gap, input string req);
      logic d, p, n, ep;
      ep = promisc | (a[40] & ref_hit(a));
      send_addr(a, gap, d, p, n);
      check(d == 1'b1, req, 32'(d), 1);
      check(p == ep, req, 32'(p), 32'(ep));
      check(n == !a[40], req, 32'(n), 32'(!a[40]));
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [47:0] a, b0, b255, x, y;
      bit f0, f255;
      for (int r = 0; r < 8; r++) model[r] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 reset state
      check(done == 1'b0, "R4 done after reset", 32'(done), 0);
      for (int r = 0; r < 8; r++) begin
         reg_sel = 3'(r);
         #1;
         check(reg_rdata == 32'h0, "R4 table reset", reg_rdata, 0);
      end

      // R4 / R6 empty table rejects group addresses
      for (int k = 0; k < 8; k++) begin
         next_addr(1'b1, a);
         try_addr(a, 0, "R4 empty table");
      end

      // R5 readback of distinct patterns
      for (int r = 0; r < 8; r++) write_reg(r, 32'h1357_9BDF ^ (32'h0101_0101 * r));
      for (int r = 0; r < 8; r++) begin
         @(negedge clk);
         reg_sel = 3'(r);
         #1;
         check(reg_rdata == model[r], "R5 readback", reg_rdata, model[r]);
      end
      for (int r = 0; r < 8; r++) write_reg(r, 32'h0);

      // R1 R2 R3 single-bin sweep: only the expected bin set, then all but it
      for (int k = 0; k < 48; k++) begin
         logic [7:0] bn;
         next_addr(1'b1, a);
         bn = ref_bin(a);
         write_reg(bn[7:5], 32'h8000_0000 >> bn[4:0]);
         try_addr(a, 0, "R1 R2 R3 bin set");
         write_reg(bn[7:5], ~(32'h8000_0000 >> bn[4:0]));
         try_addr(a, 0, "R3 bin cleared");
         write_reg(bn[7:5], 32'h0);
      end

      // R3 boundary bins 0 and 255
      f0 = 0; f255 = 0; b0 = '0; b255 = '0;
      for (int k = 0; k < 40000 && !(f0 && f255); k++) begin
         next_addr(1'b1, a);
         if (!f0 && ref_bin(a) == 8'd0) begin b0 = a; f0 = 1; end
         if (!f255 && ref_bin(a) == 8'd255) begin b255 = a; f255 = 1; end
      end
      check(f0 && f255, "R3 boundary search", 32'({f0, f255}), 3);
      write_reg(0, 32'h8000_0000);
      try_addr(b0, 0, "R3 bin 0 is reg0 msb");
      write_reg(0, 32'h7FFF_FFFF);
      try_addr(b0, 0, "R3 bin 0 other bits");
      write_reg(0, 32'h0);
      write_reg(7, 32'h0000_0001);
      try_addr(b255, 0, "R3 bin 255 is reg7 lsb");
      write_reg(7, 32'hFFFF_FFFE);
      try_addr(b255, 0, "R3 bin 255 other bits");

      // R6 individual addresses with a full table
      for (int r = 0; r < 8; r++) write_reg(r, 32'hFFFF_FFFF);
      for (int k = 0; k < 6; k++) begin
         next_addr(1'b0, a);
         try_addr(a, 0, "R6 individual ignored");
         next_addr(1'b1, a);
         try_addr(a, 0, "R6 group full table");
      end

      // R7 promiscuous with an empty table
      for (int r = 0; r < 8; r++) write_reg(r, 32'h0);
      promisc = 1'b1;
      for (int k = 0; k < 4; k++) begin
         next_addr(1'b0, a);
         try_addr(a, 0, "R7 promisc individual");
         next_addr(1'b1, a);
         try_addr(a, 0, "R7 promisc group");
      end
      promisc = 1'b0;

      // R9 idle cycles with junk bytes between address bytes
      for (int k = 0; k < 6; k++) begin
         logic [7:0] bn;
         next_addr(1'b1, a);
         bn = ref_bin(a);
         write_reg(bn[7:5], 32'h8000_0000 >> bn[4:0]);
         try_addr(a, 1 + k % 3, "R9 gaps ignored");
         write_reg(bn[7:5], 32'h0);
      end

      // R10 back-to-back addresses: x in the table, y not
      next_addr(1'b1, x);
      do next_addr(1'b1, y); while (ref_bin(y) == ref_bin(x));
      begin
         logic [7:0] bx;
         int pulses, first_at, second_at;
         logic p1, p2;
         bx = ref_bin(x);
         write_reg(bx[7:5], 32'h8000_0000 >> bx[4:0]);
         pulses = 0; first_at = -1; second_at = -1; p1 = 0; p2 = 0;
         for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (done) begin
               pulses++;
               if (pulses == 1) begin first_at = c; p1 = pass; end
               else begin second_at = c; p2 = pass; end
            end
            if (c < 12) begin
               in_valid = 1'b1;
               in_byte  = (c < 6) ? x[47-8*c -: 8] : y[47-8*(c-6) -: 8];
               in_last  = (c == 5) || (c == 11);
            end else begin
               in_valid = 1'b0; in_last = 1'b0;
            end
            @(posedge clk);
         end
         // last byte of x sampled at the edge closing iteration 5, so done is seen at iteration 7
         check(pulses == 2, "R10 two decisions", 32'(pulses), 2);
         check(first_at == 7, "R10 first timing", 32'(first_at), 7);
         check(second_at == 13, "R10 second timing", 32'(second_at), 13);
         check(p1 == 1'b1, "R10 first pass", 32'(p1), 1);
         check(p2 == 1'b0, "R10 second fresh hash", 32'(p2), 0);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule